// File: doc/BRIEF.md
# Parallel-Subunit Execute ALU

This block is the arithmetic core of a soft processor's execute stage. It takes two 32-bit operands and a 4-bit operation select. Three subunits work on the operands at the same time: an adder/subtractor, a barrel shifter and a bitwise logic unit. A final multiplexer then picks one of their results according to the operation select. The block is purely combinational.

The adder/subtractor output also leaves the block unchanged as the data-memory address. Load and store addressing therefore never passes through the result multiplexer. The same unit computes negation by subtracting the operand from zero. Absolute value uses that same difference for a negative operand and passes the operand through otherwise. Carry and zero flags are taken from the adder/subtractor. Store data is not routed through this block.

Top module: `exec_alu`

## Requirements
- R1: Operation code 0 (add) returns opnd_a + opnd_b, and code 1 (subtract) returns opnd_a - opnd_b, both modulo 2^32.
- R2: mem_addr always equals the adder/subtractor output. For codes 1, 2 and 3 this is the subtraction result, for the negation and absolute-value codes with a zero minuend. For every other code, including shift, logic and undefined codes, it is opnd_a + opnd_b, whatever result shows.
- R3: Code 2 (negate) returns 0 - opnd_a, modulo 2^32.
- R4: Code 3 (absolute) returns opnd_a when bit 31 of opnd_a is 0, and 0 - opnd_a otherwise. The input 0x80000000 returns 0x80000000, and nothing else is signalled.
- R5: Codes 4, 5 and 6 shift opnd_a left logically, right logically and right arithmetically. The shift distance is opnd_b[4:0], from 0 to 31, and opnd_b[31:5] has no effect.
- R6: Codes 7, 8 and 9 return the bitwise AND, OR and XOR of the operands. Code 10 returns ~opnd_a, and opnd_b has no effect on it.
- R7: flag_c is the carry out of the 33-bit adder/subtractor sum. When subtracting, this means 1 when there is no borrow: for code 1 it is 1 exactly when opnd_a >= opnd_b unsigned, and for codes 2 and 3 it is 1 exactly when opnd_a is 0.
- R8: flag_z is 1 exactly when the adder/subtractor output, as seen on mem_addr, is zero.
- R9: Undefined codes 11 to 15 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the subtrahend for negate and absolute |
| opnd_b | input | 32 | Second operand; its low 5 bits are the shift distance |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Selected subunit result |
| mem_addr | output | 32 | Adder/subtractor output, used as the data-memory address |
| flag_c | output | 1 | Carry out of the adder/subtractor |
| flag_z | output | 1 | Adder/subtractor output is zero |

## Verification
The bench goes after several corner cases and the fault each one would expose.

- It drives shift and logic codes while checking mem_addr. A design that routed the address through the result multiplexer would show the shifted or logic value there instead of the sum.
- It applies absolute value to zero, to -1 and to 0x80000000. A design with a misplaced sign test would negate positive values, and one that clamped or saturated would break the wrap case.
- It checks carry in the subtract-class codes at equality and at zero. An inverted borrow convention or a missing carry-in would flip flag_c there.
- It applies shift distances of 0 and 31, with junk in the upper bits of opnd_b. This catches an arithmetic shift that fills with zeros and a distance decoded from too many bits.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_NEG = 4'd2,
    OP_ABS = 4'd3,
    OP_SLL = 4'd4,
    OP_SRL = 4'd5,
    OP_SRA = 4'd6,
    OP_AND = 4'd7,
    OP_OR  = 4'd8,
    OP_XOR = 4'd9,
    OP_NOT = 4'd10
  } alu_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    sum_o,
  output logic            cout_o,
  output logic [W-1:0]    abs_o,
  output logic            abs_took_diff_o
);
  // one W+1 bit adder with optional inversion and carry-in
  function automatic logic [W:0] add_core(input logic [W-1:0] x,
                                          input logic [W-1:0] y,
                                          input logic         inv);
    logic [W-1:0] y_eff;
    y_eff = inv ? ~y : y;
    return {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, inv};
  endfunction

  logic         zero_minuend;
  logic         subtract;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W:0]   full;

  always_comb begin
    zero_minuend = (op_i == OP_NEG) || (op_i == OP_ABS);
    subtract     = zero_minuend || (op_i == OP_SUB);
    lhs          = zero_minuend ? '0 : a_i;
    rhs          = zero_minuend ? a_i : b_i;
    full         = add_core(lhs, rhs, subtract);
  end

  assign sum_o           = full[W-1:0];
  assign cout_o          = full[W];
  assign abs_took_diff_o = a_i[W-1];
  assign abs_o           = abs_took_diff_o ? full[W-1:0] : a_i;
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] amt_i,
  input  logic                 left_i,
  input  logic                 arith_i,
  output logic [W-1:0]         res_o
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] stage [SHW+1];
  logic         fill;

  assign fill     = arith_i & a_i[W-1];
  assign stage[0] = a_i;

  // log2(W) stages, stage i moves by 2**i when its distance bit is set
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int D = 1 << i;
    logic [W-1:0] moved;
    always_comb begin
      if (left_i) moved = {stage[i][W-D-1:0], {D{1'b0}}};
      else        moved = {{D{fill}}, stage[i][W-1:D]};
    end
    assign stage[i+1] = amt_i[i] ? moved : stage[i];
  end

  assign res_o = stage[SHW];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [W-1:0]    res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [3:0]      op_sel,
  output logic [W-1:0]    result,
  output logic [W-1:0]    mem_addr,
  output logic            flag_c,
  output logic            flag_z
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] add_sum;
  logic         add_cout;
  logic [W-1:0] abs_val;
  logic         abs_took_diff;
  logic [W-1:0] shf_res;
  logic [W-1:0] lgc_res;
  logic         shf_left;
  logic         shf_arith;

  assign shf_left  = (op_sel == OP_SLL);
  assign shf_arith = (op_sel == OP_SRA);

  alu_addsub #(.W(W)) u_addsub (
    .a_i(opnd_a), .b_i(opnd_b), .op_i(op_sel),
    .sum_o(add_sum), .cout_o(add_cout),
    .abs_o(abs_val), .abs_took_diff_o(abs_took_diff)
  );

  alu_shifter #(.W(W)) u_shift (
    .a_i(opnd_a), .amt_i(opnd_b[SHW-1:0]),
    .left_i(shf_left), .arith_i(shf_arith), .res_o(shf_res)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(opnd_a), .b_i(opnd_b), .op_i(op_sel), .res_o(lgc_res)
  );

  // the address leaves straight from the adder, ahead of the mux
  assign mem_addr = add_sum;
  assign flag_c   = add_cout;
  assign flag_z   = (add_sum == '0);

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB, OP_NEG:  result = add_sum;
      OP_ABS:                  result = abs_val;
      OP_SLL, OP_SRL, OP_SRA:  result = shf_res;
      OP_AND, OP_OR, OP_XOR,
      OP_NOT:                  result = lgc_res;
      default:                 result = '0;
    endcase
  end
endmodule

// File: rtl/exec_alu_chk.sv
module exec_alu_chk
  import exec_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [3:0]   op_sel,
  input logic [W-1:0] result,
  input logic [W-1:0] mem_addr,
  input logic         flag_z,
  input logic         abs_took_diff
);
  logic [W-1:0] plain_sum;
  logic         non_arith;
  assign plain_sum = opnd_a + opnd_b;
  assign non_arith = (op_sel > OP_ABS);

  always_comb begin
    // R2
    addr_on_add_chk: assert (op_sel != OP_ADD || result == mem_addr);
    // R2
    addr_bypass_chk: assert (!non_arith || mem_addr == plain_sum);
    // R3
    neg_cancels_chk: assert (op_sel != OP_NEG || (result + opnd_a) == '0);
    // R4
    abs_sign_chk: assert (op_sel != OP_ABS || opnd_a == {1'b1, {(W-1){1'b0}}}
                          || !result[W-1]);
    // R4
    abs_pass_chk: assert (op_sel != OP_ABS || abs_took_diff || result == opnd_a);
    // R8
    zero_flag_chk: assert (flag_z == (mem_addr == '0));
    // R9
    undef_zero_chk: assert (op_sel <= OP_NOT || result == '0);
  end
endmodule

bind exec_alu exec_alu_chk #(.W(W)) i_exec_alu_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
  .result(result), .mem_addr(mem_addr), .flag_z(flag_z),
  .abs_took_diff(abs_took_diff)
);

// File: tb/test_exec_alu.sv
module test_exec_alu;
  logic        clk = 1'b0;
  logic [31:0] opnd_a, opnd_b;
  logic [3:0]  op_sel;
  logic [31:0] result, mem_addr;
  logic        flag_c, flag_z;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  exec_alu i_exec_alu (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
    .result(result), .mem_addr(mem_addr), .flag_c(flag_c), .flag_z(flag_z)
  );

  task automatic cmp(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // model built from the requirement text
  task automatic apply(input string req, input logic [3:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er, ea;
    logic        ec;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b;
    #1;
    case (op)
      4'd1:    begin ea = a - b; ec = (a >= b); end
      4'd2, 4'd3: begin ea = 32'd0 - a; ec = (a == 32'd0); end
      default: begin ea = a + b; ec = ((33'(a) + 33'(b)) >> 32) != 0; end
    endcase
    case (op)
      4'd0, 4'd1, 4'd2: er = ea;
      4'd3:  er = ($signed(a) < 0) ? -a : a;
      4'd4:  er = a << b[4:0];
      4'd5:  er = a >> b[4:0];
      4'd6:  er = $unsigned($signed(a) >>> b[4:0]);
      4'd7:  er = a & b;
      4'd8:  er = a | b;
      4'd9:  er = a ^ b;
      4'd10: er = ~a;
      default: er = 32'd0;
    endcase
    cmp(req, "result", result, er);
    cmp("R2", "mem_addr", mem_addr, ea);
    cmp("R7", "flag_c", {31'd0, flag_c}, {31'd0, ec});
    cmp("R8", "flag_z", {31'd0, flag_z}, {31'd0, ea == 32'd0});
  endtask

  task automatic t_idle();
    apply("R1", 4'd0, 32'd0, 32'd0);
  endtask

  task automatic t_addsub();
    apply("R1", 4'd0, 32'h0000_1234, 32'h0000_0010);
    apply("R1", 4'd0, 32'hFFFF_FFFF, 32'h0000_0001);
    apply("R1", 4'd1, 32'h0000_0005, 32'h0000_0005);
    apply("R1", 4'd1, 32'h0000_0003, 32'h0000_0007);
    apply("R1", 4'd1, 32'h8000_0000, 32'h0000_0001);
  endtask

  task automatic t_neg_abs();
    apply("R3", 4'd2, 32'd0, 32'hDEAD_BEEF);
    apply("R3", 4'd2, 32'd1, 32'd0);
    apply("R3", 4'd2, 32'h8000_0000, 32'd9);
    apply("R4", 4'd3, 32'd0, 32'd0);
    apply("R4", 4'd3, 32'hFFFF_FFFF, 32'd0);
    apply("R4", 4'd3, 32'h7FFF_FFFF, 32'd3);
    apply("R4", 4'd3, 32'h8000_0000, 32'd0);
    apply("R4", 4'd3, 32'hFFFF_FF85, 32'h1234_0000);
  endtask

  task automatic t_shift();
    apply("R5", 4'd4, 32'h8000_0001, 32'd0);
    apply("R5", 4'd4, 32'h0000_0001, 32'd31);
    apply("R5", 4'd4, 32'h0000_00F0, 32'hFFFF_FFE4);
    apply("R5", 4'd5, 32'h8000_0000, 32'd31);
    apply("R5", 4'd5, 32'hF000_000F, 32'h0000_0124);
    apply("R5", 4'd6, 32'h8000_0000, 32'd31);
    apply("R5", 4'd6, 32'h8765_4321, 32'hABCD_0008);
    apply("R5", 4'd6, 32'h4765_4321, 32'd7);
  endtask

  task automatic t_logic();
    apply("R6", 4'd7, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    apply("R6", 4'd8, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    apply("R6", 4'd9, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    apply("R6", 4'd10, 32'h1234_5678, 32'h0000_0000);
    apply("R6", 4'd10, 32'h1234_5678, 32'hFFFF_FFFF);
  endtask

  task automatic t_undef();
    for (int k = 11; k < 16; k++)
      apply("R9", 4'(k), 32'hCAFE_0000 + 32'(k), 32'h0101_0101);
  endtask

  initial begin
    opnd_a = '0; opnd_b = '0; op_sel = '0;
    t_idle();
    t_addsub();
    t_neg_abs();
    t_shift();
    t_logic();
    t_undef();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule